// File: doc/BRIEF.md
# Registered OR-Merge Shared Bus

This block is a shared broadcast bus for a row of agents, built with no tri-state drivers. Each agent owns a source register. When the agent is granted, the register loads a beat made of a valid bit and a data word. When it is not granted, the register loads all zeros. The source registers are merged by two OR chains, one per transceiver, starting at the two ends of the row. The left chain covers agents `0 .. AGENTS/2-1` and the right chain covers the rest. The two chains meet at the middle, and the combined beat is broadcast back to every agent.

Arbitration lives outside the block. The block only receives a grant vector with at most one bit set per cycle.

A four-bit parameter turns on optional retiming registers at fixed positions along the path:
- bit 0: at the output of each half chain;
- bit 1: after the middle merge;
- bit 2: at each agent's return tap;
- bit 3: on entry to each receiving agent.

Every receiver sees the same beat in the same cycle. The latency from a grant to the beat at the receivers is one cycle for the source register plus one cycle for each enabled position.

Top module: `orbus_top`

## Requirements
- R1: While `rst_n` is low, and in the first sampled cycle after any reset, every `rx_valid` bit is 0 and every `rx_data` word is 0.
- R2: A beat granted to agent k, with `grant[k]` high and data `tx_data[k*DATA_W +: DATA_W]` sampled at a clock edge, appears with `rx_valid` = 1 and that data at the receivers exactly `1 + popcount(STAGE_EN)` clock edges later. `STAGE_EN` bit 0 is the half-chain output, bit 1 the middle merge, bit 2 the return tap, and bit 3 the receive entry.
- R3: The data of agents whose grant bit is low has no effect. When no grant bit is set, the receivers show `rx_valid` = 0 and `rx_data` = 0 after the latency of R2. At most one grant bit may be high in a cycle.
- R4: Every receiver `0 .. AGENTS-1` shows the same beat in the same cycle. The latency does not depend on which agent sourced the beat, whether it sits in the left half, the right half, at an end or next to the middle.
- R5: Grants to different agents in consecutive cycles deliver one beat per cycle, in grant order, with no gap and no merging.
- R6: A granted all-zero data word still arrives with `rx_valid` = 1, and an all-ones word arrives unchanged.
- R7: Asserting reset while beats are in flight discards them. After release, only beats granted from the release cycle onward appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | AGENTS | One-hot-or-zero grant, bit k lets agent k drive the bus |
| tx_data | input | AGENTS*DATA_W | Agent k's outgoing word in bits `k*DATA_W +: DATA_W` |
| rx_data | output | AGENTS*DATA_W | Broadcast word as seen by agent k in bits `k*DATA_W +: DATA_W` |
| rx_valid | output | AGENTS | Bit k qualifies agent k's received word |

## Verification
The same stimulus drives four instances whose stage enables give latencies of 1, 3, 5 and 3. In the 3-cycle pair, different positions are enabled, so a wrong stage position or a missing balance register shows up as a latency mismatch.

Each agent is granted alone with idle gaps, which separates left-half, right-half, end and middle sources. Noisy data on non-granted agents, including fully idle cycles, would expose any agent that leaks onto the OR merge. Back-to-back grants across both halves expose beats that collide or slip. All-zero and all-ones words separate the valid bit from the data bits. A reset in the middle of a burst shows whether in-flight beats are really flushed.

// File: rtl/orbus_pkg.sv
`timescale 1ns/1ps
package orbus_pkg;

  // Retiming positions along the source-to-receiver path
  localparam int unsigned STG_FWD   = 0;  // end of each half OR chain
  localparam int unsigned STG_MID   = 1;  // after the middle merge
  localparam int unsigned STG_TAP   = 2;  // per-agent return tap
  localparam int unsigned STG_RX    = 3;  // receive entry of each agent
  localparam int unsigned STG_SLOTS = 4;

  function automatic int unsigned stage_count(input logic [STG_SLOTS-1:0] en);
    int unsigned c;
    c = 0;
    for (int k = 0; k < STG_SLOTS; k++) begin
      if (en[k]) c++;
    end
    return c;
  endfunction

  // Source register plus every enabled retiming position
  function automatic int unsigned bus_latency(input logic [STG_SLOTS-1:0] en);
    return 1 + stage_count(en);
  endfunction

  function automatic int unsigned left_count(input int unsigned agents);
    return agents / 2;
  endfunction

endpackage

// File: rtl/orbus_stage.sv
`timescale 1ns/1ps
module orbus_stage #(
  parameter int unsigned WIDTH  = 17,
  parameter bit          ENABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (ENABLE) begin : g_reg
      logic [WIDTH-1:0] q_r;
      logic             seen_edge;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r       <= '0;
          seen_edge <= 1'b0;
        end else begin
          q_r       <= d;
          seen_edge <= 1'b1;
        end
      end
      assign q = q_r;

      AST_STAGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |-> (q == $past(d)));  // R2
    end else begin : g_wire
      logic unused_pins;
      assign unused_pins = clk ^ rst_n;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/orbus_src.sv
`timescale 1ns/1ps
module orbus_src #(
  parameter int unsigned DATA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W:0] beat_q
);

  // A non-granted agent drives all zeros so the OR merge passes only the owner
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= grant_i ? {1'b1, data_i} : '0;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_i |=> (beat_q == '0));  // R3

  AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |=> (beat_q == {1'b1, $past(data_i)}));  // R2

endmodule

// File: rtl/orbus_chain.sv
`timescale 1ns/1ps
module orbus_chain #(
  parameter int unsigned BEAT_W = 17,
  parameter int unsigned CNT    = 3
) (
  input  logic [CNT*BEAT_W-1:0] taps_i,   // tap 0 is the far end
  output logic [BEAT_W-1:0]     merged_o
);

  logic [BEAT_W-1:0] part [CNT];

  assign part[0] = taps_i[0 +: BEAT_W];

  // One two-input OR per transceiver: local beat OR value from the neighbour
  generate
    for (genvar k = 1; k < CNT; k++) begin : g_hop
      assign part[k] = part[k-1] | taps_i[k*BEAT_W +: BEAT_W];
    end
  endgenerate

  assign merged_o = part[CNT-1];

endmodule

// File: rtl/orbus_top.sv
`timescale 1ns/1ps
module orbus_top import orbus_pkg::*; #(
  parameter int unsigned          AGENTS   = 6,
  parameter int unsigned          DATA_W   = 16,
  parameter logic [STG_SLOTS-1:0] STAGE_EN = 4'b1001
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AGENTS-1:0]        grant,
  input  logic [AGENTS*DATA_W-1:0] tx_data,
  output logic [AGENTS*DATA_W-1:0] rx_data,
  output logic [AGENTS-1:0]        rx_valid
);

  localparam int unsigned BEAT_W  = DATA_W + 1;
  localparam int unsigned LEFT_N  = left_count(AGENTS);
  localparam int unsigned RIGHT_N = AGENTS - LEFT_N;
  localparam int unsigned LAT     = bus_latency(STAGE_EN);

  // ---------------- source registers ----------------
  logic [BEAT_W-1:0] src_beat [AGENTS];
  logic [AGENTS-1:0] src_valid_vec;

  generate
    for (genvar i = 0; i < AGENTS; i++) begin : g_agent
      orbus_src #(.DATA_W(DATA_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (grant[i]),
        .data_i  (tx_data[i*DATA_W +: DATA_W]),
        .beat_q  (src_beat[i])
      );
      assign src_valid_vec[i] = src_beat[i][DATA_W];
    end
  endgenerate

  // ---------------- two OR chains toward the middle ----------------
  logic [LEFT_N*BEAT_W-1:0]  left_taps;
  logic [RIGHT_N*BEAT_W-1:0] right_taps;
  logic [BEAT_W-1:0]         left_merged, right_merged;
  logic [BEAT_W-1:0]         left_fwd, right_fwd;

  generate
    for (genvar i = 0; i < LEFT_N; i++) begin : g_left
      assign left_taps[i*BEAT_W +: BEAT_W] = src_beat[i];
    end
    for (genvar i = 0; i < RIGHT_N; i++) begin : g_right
      assign right_taps[i*BEAT_W +: BEAT_W] = src_beat[AGENTS-1-i];
    end
  endgenerate

  orbus_chain #(.BEAT_W(BEAT_W), .CNT(LEFT_N)) u_chain_l (
    .taps_i (left_taps), .merged_o (left_merged)
  );
  orbus_chain #(.BEAT_W(BEAT_W), .CNT(RIGHT_N)) u_chain_r (
    .taps_i (right_taps), .merged_o (right_merged)
  );

  orbus_stage #(.WIDTH(BEAT_W), .ENABLE(STAGE_EN[STG_FWD])) u_fwd_l (
    .clk (clk), .rst_n (rst_n), .d (left_merged), .q (left_fwd)
  );
  orbus_stage #(.WIDTH(BEAT_W), .ENABLE(STAGE_EN[STG_FWD])) u_fwd_r (
    .clk (clk), .rst_n (rst_n), .d (right_merged), .q (right_fwd)
  );

  // ---------------- middle merge and broadcast ----------------
  logic [BEAT_W-1:0] mid_merge;
  logic [BEAT_W-1:0] bcast_beat;

  assign mid_merge = left_fwd | right_fwd;

  orbus_stage #(.WIDTH(BEAT_W), .ENABLE(STAGE_EN[STG_MID])) u_mid (
    .clk (clk), .rst_n (rst_n), .d (mid_merge), .q (bcast_beat)
  );

  // ---------------- return path to every agent ----------------
  logic [BEAT_W-1:0] tap_beat [AGENTS];
  logic [BEAT_W-1:0] rx_beat  [AGENTS];

  generate
    for (genvar i = 0; i < AGENTS; i++) begin : g_rx
      orbus_stage #(.WIDTH(BEAT_W), .ENABLE(STAGE_EN[STG_TAP])) u_tap (
        .clk (clk), .rst_n (rst_n), .d (bcast_beat), .q (tap_beat[i])
      );
      orbus_stage #(.WIDTH(BEAT_W), .ENABLE(STAGE_EN[STG_RX])) u_entry (
        .clk (clk), .rst_n (rst_n), .d (tap_beat[i]), .q (rx_beat[i])
      );
      assign rx_data[i*DATA_W +: DATA_W] = rx_beat[i][DATA_W-1:0];
      assign rx_valid[i]                 = rx_beat[i][DATA_W];
    end
  endgenerate

  // ---------------- checking support ----------------
  // Reference selection written as a priority search, not as an OR merge
  function automatic logic [BEAT_W-1:0] pick_beat(
    input logic [AGENTS-1:0]        g,
    input logic [AGENTS*DATA_W-1:0] d
  );
    logic [BEAT_W-1:0] r;
    logic              found;
    r     = '0;
    found = 1'b0;
    for (int k = 0; k < AGENTS; k++) begin
      if (g[k] && !found) begin
        r     = {1'b1, d[k*DATA_W +: DATA_W]};
        found = 1'b1;
      end
    end
    return r;
  endfunction

  logic [BEAT_W-1:0] ref_beat;
  logic [3:0]        settle_cnt;

  assign ref_beat = pick_beat(grant, tx_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  settle_cnt <= '0;
    else if (settle_cnt < 4'(LAT)) settle_cnt <= settle_cnt + 4'd1;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R3

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_valid_vec) <= 1);  // R3

  AST_RX_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid == '0) || (&rx_valid));  // R4

  generate
    for (genvar i = 0; i < AGENTS; i++) begin : g_chk
      AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_cnt >= 4'(LAT)) |-> (rx_beat[i] == $past(ref_beat, LAT)));  // R2
    end
  endgenerate

endmodule

// File: tb/tb_orbus_top.sv
`timescale 1ns/1ps
module tb_orbus_top;

  localparam int N = 6;
  localparam int W = 16;
  localparam int B = W + 1;
  localparam int NCFG = 4;
  localparam logic [3:0] CFG0 = 4'b0000;
  localparam logic [3:0] CFG1 = 4'b1001;
  localparam logic [3:0] CFG2 = 4'b1111;
  localparam logic [3:0] CFG3 = 4'b0110;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [N-1:0]   grant = '0;
  logic [N*W-1:0] tx_data = '0;
  logic [N*W-1:0] rxd [NCFG];
  logic [N-1:0]   rxv [NCFG];

  orbus_top #(.AGENTS(N), .DATA_W(W), .STAGE_EN(CFG1)) dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .tx_data(tx_data),
    .rx_data(rxd[1]), .rx_valid(rxv[1]));
  orbus_top #(.AGENTS(N), .DATA_W(W), .STAGE_EN(CFG0)) dut_b (
    .clk(clk), .rst_n(rst_n), .grant(grant), .tx_data(tx_data),
    .rx_data(rxd[0]), .rx_valid(rxv[0]));
  orbus_top #(.AGENTS(N), .DATA_W(W), .STAGE_EN(CFG2)) dut_c (
    .clk(clk), .rst_n(rst_n), .grant(grant), .tx_data(tx_data),
    .rx_data(rxd[2]), .rx_valid(rxv[2]));
  orbus_top #(.AGENTS(N), .DATA_W(W), .STAGE_EN(CFG3)) dut_d (
    .clk(clk), .rst_n(rst_n), .grant(grant), .tx_data(tx_data),
    .rx_data(rxd[3]), .rx_valid(rxv[3]));

  int     lat_of [NCFG];
  logic [B-1:0] hist [0:1023];
  int     n = 0;
  int     rst_mark = 0;
  int     checks = 0;
  int     fails = 0;
  bit     done = 1'b0;
  string  cur_req = "R1";

  // Compare every receiver of every instance with the beat injected latency steps ago
  task automatic compare_all();
    for (int c = 0; c < NCFG; c++) begin
      int           idx;
      logic [B-1:0] exp;
      logic [B-1:0] got;
      bit           bad;
      idx = n - lat_of[c];
      exp = '0;
      if (idx >= 0 && idx >= rst_mark) exp = hist[idx];
      bad = 1'b0;
      checks++;
      for (int a = 0; a < N; a++) begin
        got = {rxv[c][a], rxd[c][a*W +: W]};
        if (got !== exp && !bad) begin
          bad = 1'b1;
          fails++;
          $display("FAIL %s cfg=%0d agent=%0d actual=%h expected=%h",
                   cur_req, c, a, got, exp);
        end
      end
    end
  endtask

  // One cycle: check outputs, then apply inputs for the next edge
  task automatic step(input int gi, input logic [W-1:0] val,
                      input logic [W-1:0] noise, input logic rst_val);
    @(negedge clk);
    compare_all();
    rst_n = rst_val;
    grant = '0;
    for (int j = 0; j < N; j++) begin
      if (j == gi) tx_data[j*W +: W] = val;
      else         tx_data[j*W +: W] = noise ^ W'(j * 16'h1111);
    end
    if (gi >= 0) grant[gi] = 1'b1;
    if (!rst_val) rst_mark = n;
    hist[n] = (gi >= 0 && rst_val) ? {1'b1, val} : '0;
    n++;
  endtask

  task automatic idle(input int cycles, input logic [W-1:0] noise);
    for (int k = 0; k < cycles; k++) step(-1, '0, noise, 1'b1);
  endtask

  task automatic t_reset_r1();
    cur_req = "R1";
    for (int k = 0; k < 3; k++) step(-1, '0, 16'h5A5A, 1'b0);
    step(-1, '0, 16'h0000, 1'b1);
    idle(2, 16'h0000);
  endtask

  task automatic t_each_agent_r4();
    cur_req = "R4";
    for (int a = 0; a < N; a++) begin
      step(a, W'(16'h1200 + a * 16'h0101), 16'h0000, 1'b1);
      idle(6, 16'h0000);
    end
  endtask

  task automatic t_latency_r2();
    cur_req = "R2";
    step(2, 16'hC3A5, 16'h0000, 1'b1);
    idle(6, 16'h0000);
    step(3, 16'h3C5A, 16'h0000, 1'b1);
    idle(6, 16'h0000);
  endtask

  task automatic t_noise_r3();
    cur_req = "R3";
    idle(7, 16'hFFFF);
    step(4, 16'h0F0F, 16'hF0F0, 1'b1);
    idle(6, 16'hBEEF);
    step(0, 16'h1001, 16'h7777, 1'b1);
    idle(6, 16'h6666);
  endtask

  task automatic t_back_to_back_r5();
    cur_req = "R5";
    for (int a = 0; a < N; a++) step(N - 1 - a, W'(16'hA000 + a), 16'h0000, 1'b1);
    for (int a = 0; a < N; a++) step(a, W'(16'hB000 + a), 16'h2222, 1'b1);
    idle(6, 16'h0000);
  endtask

  task automatic t_extremes_r6();
    cur_req = "R6";
    step(1, 16'h0000, 16'hFFFF, 1'b1);
    idle(6, 16'h0000);
    step(5, 16'hFFFF, 16'h0000, 1'b1);
    idle(6, 16'h0000);
  endtask

  task automatic t_mid_reset_r7();
    cur_req = "R7";
    for (int a = 0; a < 4; a++) step(a, W'(16'hD000 + a), 16'h0000, 1'b1);
    step(-1, '0, 16'h0000, 1'b0);
    step(-1, '0, 16'h0000, 1'b0);
    step(2, 16'hE00E, 16'h0000, 1'b1);
    step(4, 16'hE11E, 16'h0000, 1'b1);
    idle(7, 16'h0000);
  endtask

  initial begin
    for (int c = 0; c < NCFG; c++) lat_of[c] = 0;
    lat_of[0] = 1 + $countones(CFG0);
    lat_of[1] = 1 + $countones(CFG1);
    lat_of[2] = 1 + $countones(CFG2);
    lat_of[3] = 1 + $countones(CFG3);
    for (int k = 0; k < 1024; k++) hist[k] = '0;
    t_reset_r1();
    t_each_agent_r4();
    t_latency_r2();
    t_noise_r3();
    t_back_to_back_r5();
    t_extremes_r6();
    t_mid_reset_r7();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule